// File: doc/BRIEF.md
# Write-Through Byte Cache

This block is a small fully associative data cache that sits between a processor request port and a slower memory. The processor issues one byte load or one byte store at a time on a 5-bit byte address. It holds the request until the cache answers with a single-cycle ready pulse. For a load, the byte is valid on the read-data output during that pulse.

The cache writes through and allocates on writes. Any miss, load or store, first fetches the whole two-byte line from memory into a line chosen by the replacement logic. Every store then updates the cached copy and also sends exactly one byte write to memory. Memory therefore always holds current data, and replacing a line never generates memory traffic. The memory side has two request/done handshakes: one returns a full line for a line address, and one accepts a single byte at a byte address. Hit and miss counters count completed lookups.

Top module: `wt_cache`

## Requirements
- R1: While and after reset, no line is valid, both counters read zero, ready is low and no memory request is raised.
- R2: A load miss raises one line-read request for the line address (byte address bits 4:1). It waits for done and returns the byte selected by address bit 0, where offset 0 is line-data bits 7:0 and offset 1 is bits 15:8. The miss counter increases by one.
- R3: A load hit raises no memory request, increments the hit counter, and pulses ready exactly one cycle after the request is first seen.
- R4: A store hit updates the cached byte and issues exactly one byte-write request carrying the store's full byte address and data. The other byte of the line is kept.
- R5: A store miss first reads the whole line, merges the store byte into it, and then issues the single byte write. A later load of either byte of that line hits.
- R6: Memory writes occur only for stores, exactly one per store. Replacing a line never writes memory.
- R7: On a miss, an invalid line is filled before any valid line is replaced. Otherwise the least recently used line is replaced, with recency updated on every hit and every fill.
- R8: Ready stays low until every line read and byte write belonging to the access has completed. It then goes high for exactly one cycle.
- R9: The line-read and byte-write requests are never raised together. Each stays raised until its done input is seen.
- R10: Loaded data always equals the current memory contents at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Processor access request, held until ready |
| req_store_i | input | 1 | 1 = byte store, 0 = byte load |
| req_addr_i | input | 5 | Byte address |
| req_wdata_i | input | 8 | Store data |
| req_ready_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Load data, valid with ready |
| mem_rd_req_o | output | 1 | Line read request |
| mem_rd_line_o | output | 4 | Line address to read |
| mem_rd_data_i | input | 16 | Returned line, offset 0 in bits 7:0 |
| mem_rd_done_i | input | 1 | Line read complete, data valid |
| mem_wr_req_o | output | 1 | Byte write request |
| mem_wr_addr_o | output | 5 | Byte write address |
| mem_wr_data_o | output | 8 | Byte write data |
| mem_wr_done_i | input | 1 | Byte write complete |
| hit_cnt_o | output | 16 | Lookups that hit |
| miss_cnt_o | output | 16 | Lookups that missed |

## Verification
Some properties are checked on every cycle by the assertions:
- the two memory requests never overlap, and each is held until its done arrives;
- a byte write happens only for a store;
- ready is a single-cycle pulse;
- lines never hold duplicate tags;
- every new line read coincides with a miss count;
- the line just used is never the next victim.

Other behaviour needs the bench scenarios:
- that loaded bytes track memory through fills, merges and evictions;
- that replacement order yields the expected hit and miss counts;
- that the written address and data match the store;
- that ready waits for delayed memory responses.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int NUM_LINES = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_match.sv
module wtc_tag_match #(
  parameter int N     = 2,
  parameter int TAG_W = 4,
  parameter int WAY_W = 1
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]        tag_i,
  output logic [N-1:0]            hit_vec_o,
  output logic                    hit_o,
  output logic [WAY_W-1:0]        hit_way_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < N; w++) begin
      if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wtc_victim.sv
module wtc_victim #(
  parameter int N     = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (touch_i) lru_q <= ~touch_way_i;
  end

  // invalid lines first, lowest index wins
  always_comb begin
    victim_o = lru_q;
    for (int w = N - 1; w >= 0; w--) begin
      if (!valid_i[w]) victim_o = WAY_W'(w);
    end
  end

  assert_lru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && (&valid_i)) |=> (victim_o != $past(touch_way_i)));
endmodule

// File: rtl/wtc_lines.sv
module wtc_lines #(
  parameter int N      = 2,
  parameter int TAG_W  = 4,
  parameter int LINE_W = 16,
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 1,
  parameter int WAY_W  = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fill_en_i,
  input  logic [WAY_W-1:0]         fill_way_i,
  input  logic [TAG_W-1:0]         fill_tag_i,
  input  logic [LINE_W-1:0]        fill_line_i,
  input  logic                     wr_en_i,
  input  logic [WAY_W-1:0]         wr_way_i,
  input  logic [OFF_W-1:0]         wr_off_i,
  input  logic [BYTE_W-1:0]        wr_byte_i,
  output logic [N-1:0]             valid_o,
  output logic [N-1:0][TAG_W-1:0]  tags_o,
  output logic [N-1:0][LINE_W-1:0] lines_o
);
  localparam int WORDS = LINE_W / BYTE_W;

  for (genvar g = 0; g < N; g++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        tags_o[g]  <= '0;
        lines_o[g] <= '0;
      end else if (fill_en_i && fill_way_i == WAY_W'(g)) begin
        valid_o[g] <= 1'b1;
        tags_o[g]  <= fill_tag_i;
        lines_o[g] <= fill_line_i;
      end else if (wr_en_i && wr_way_i == WAY_W'(g)) begin
        for (int w = 0; w < WORDS; w++) begin
          if (wr_off_i == OFF_W'(w)) lines_o[g][w*BYTE_W +: BYTE_W] <= wr_byte_i;
        end
      end
    end
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_store_i,
  input  logic hit_i,
  input  logic store_q_i,
  input  logic rd_done_i,
  input  logic wr_done_i,
  output logic lookup_o,
  output logic fill_fire_o,
  output logic rd_req_o,
  output logic wr_req_o,
  output logic ready_o
);
  wtc_state_e state_q, state_d;

  assign lookup_o    = (state_q == ST_IDLE) && req_valid_i;
  assign fill_fire_o = (state_q == ST_FILL) && rd_done_i;
  assign rd_req_o    = (state_q == ST_FILL);
  assign wr_req_o    = (state_q == ST_WRITE);
  assign ready_o     = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = !hit_i ? ST_FILL : (req_store_i ? ST_WRITE : ST_DONE);
      ST_FILL:  if (rd_done_i)   state_d = store_q_i ? ST_WRITE : ST_DONE;
      ST_WRITE: if (wr_done_i)   state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  assert_rd_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_done_i) |=> rd_req_o);
  assert_wr_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_done_i) |=> wr_req_o);
  assert_wr_store_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> store_q_i);
  assert_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   req_valid_i,
  input  logic                                   req_store_i,
  input  logic [ADDR_W-1:0]                      req_addr_i,
  input  logic [BYTE_W-1:0]                      req_wdata_i,
  output logic                                   req_ready_o,
  output logic [BYTE_W-1:0]                      rsp_rdata_o,
  output logic                                   mem_rd_req_o,
  output logic [ADDR_W-OFF_W-1:0]                mem_rd_line_o,
  input  logic [(BYTE_W*(2**OFF_W))-1:0]         mem_rd_data_i,
  input  logic                                   mem_rd_done_i,
  output logic                                   mem_wr_req_o,
  output logic [ADDR_W-1:0]                      mem_wr_addr_o,
  output logic [BYTE_W-1:0]                      mem_wr_data_o,
  input  logic                                   mem_wr_done_i,
  output logic [CNT_W-1:0]                       hit_cnt_o,
  output logic [CNT_W-1:0]                       miss_cnt_o
);
  localparam int N      = NUM_LINES;
  localparam int WAY_W  = (N > 1) ? $clog2(N) : 1;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int WORDS  = 2 ** OFF_W;
  localparam int LINE_W = BYTE_W * WORDS;

  logic [N-1:0]             valid;
  logic [N-1:0][TAG_W-1:0]  tags;
  logic [N-1:0][LINE_W-1:0] lines;
  logic [N-1:0]             hit_vec;
  logic                     hit;
  logic [WAY_W-1:0]         hit_way, victim;
  logic                     lookup, fill_fire;

  logic [ADDR_W-1:0]        addr_q;
  logic                     store_q;
  logic [BYTE_W-1:0]        wdata_q, rdata_q;
  logic [WAY_W-1:0]         way_q;

  logic [TAG_W-1:0]         req_tag;
  logic [OFF_W-1:0]         req_off, off_q;
  logic [BYTE_W-1:0]        hit_byte, fill_byte;
  logic [LINE_W-1:0]        fill_line;
  logic                     touch;
  logic [WAY_W-1:0]         touch_way;

  assign req_tag = req_addr_i[ADDR_W-1:OFF_W];
  assign req_off = req_addr_i[OFF_W-1:0];
  assign off_q   = addr_q[OFF_W-1:0];

  wtc_tag_match #(.N(N), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid_i   (valid),
    .tags_i    (tags),
    .tag_i     (req_tag),
    .hit_vec_o (hit_vec),
    .hit_o     (hit),
    .hit_way_o (hit_way)
  );

  assign touch     = (lookup && hit) || fill_fire;
  assign touch_way = fill_fire ? way_q : hit_way;

  wtc_victim #(.N(N), .WAY_W(WAY_W)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid),
    .touch_i     (touch),
    .touch_way_i (touch_way),
    .victim_o    (victim)
  );

  wtc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_store_i (req_store_i),
    .hit_i       (hit),
    .store_q_i   (store_q),
    .rd_done_i   (mem_rd_done_i),
    .wr_done_i   (mem_wr_done_i),
    .lookup_o    (lookup),
    .fill_fire_o (fill_fire),
    .rd_req_o    (mem_rd_req_o),
    .wr_req_o    (mem_wr_req_o),
    .ready_o     (req_ready_o)
  );

  // byte select on hit, byte select and store merge on fill
  always_comb begin
    hit_byte  = '0;
    fill_byte = '0;
    fill_line = mem_rd_data_i;
    for (int w = 0; w < WORDS; w++) begin
      if (req_off == OFF_W'(w)) hit_byte = lines[hit_way][w*BYTE_W +: BYTE_W];
      if (off_q == OFF_W'(w)) begin
        fill_byte = mem_rd_data_i[w*BYTE_W +: BYTE_W];
        if (store_q) fill_line[w*BYTE_W +: BYTE_W] = wdata_q;
      end
    end
  end

  wtc_lines #(
    .N(N), .TAG_W(TAG_W), .LINE_W(LINE_W), .BYTE_W(BYTE_W), .OFF_W(OFF_W), .WAY_W(WAY_W)
  ) u_lines (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_en_i   (fill_fire),
    .fill_way_i  (way_q),
    .fill_tag_i  (addr_q[ADDR_W-1:OFF_W]),
    .fill_line_i (fill_line),
    .wr_en_i     (lookup && hit && req_store_i),
    .wr_way_i    (hit_way),
    .wr_off_i    (req_off),
    .wr_byte_i   (req_wdata_i),
    .valid_o     (valid),
    .tags_o      (tags),
    .lines_o     (lines)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      store_q    <= 1'b0;
      wdata_q    <= '0;
      way_q      <= '0;
      rdata_q    <= '0;
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      if (lookup) begin
        addr_q  <= req_addr_i;
        store_q <= req_store_i;
        wdata_q <= req_wdata_i;
        way_q   <= hit ? hit_way : victim;
        if (hit) begin
          hit_cnt_o <= hit_cnt_o + 1'b1;
          if (!req_store_i) rdata_q <= hit_byte;
        end else begin
          miss_cnt_o <= miss_cnt_o + 1'b1;
        end
      end
      if (fill_fire && !store_q) rdata_q <= fill_byte;
    end
  end

  assign rsp_rdata_o   = rdata_q;
  assign mem_rd_line_o = addr_q[ADDR_W-1:OFF_W];
  assign mem_wr_addr_o = addr_q;
  assign mem_wr_data_o = wdata_q;

  assert_unique_tags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  assert_fill_counted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rd_req_o) |-> (miss_cnt_o != $past(miss_cnt_o)));
  assert_wr_line_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_req_o) |-> valid[way_q]);
endmodule

// File: tb/wt_cache_test.sv
module wt_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic        mem_rd_req, mem_rd_done = 1'b0;
  logic [3:0]  mem_rd_line;
  logic [15:0] mem_rd_data = '0;
  logic        mem_wr_req, mem_wr_done = 1'b0;
  logic [4:0]  mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic [15:0] hit_cnt, miss_cnt;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [4:0] last_wr_addr = '0;
  logic [7:0] last_wr_data = '0;
  logic [7:0] mem_model [32];

  // reference cache state
  bit         m_valid [2];
  logic [3:0] m_tag   [2];
  bit         m_lru = 1'b0;
  int         exp_hits = 0, exp_misses = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  wt_cache uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_store_i(req_store), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .rsp_rdata_o(rsp_rdata),
    .mem_rd_req_o(mem_rd_req), .mem_rd_line_o(mem_rd_line), .mem_rd_data_i(mem_rd_data),
    .mem_rd_done_i(mem_rd_done), .mem_wr_req_o(mem_wr_req), .mem_wr_addr_o(mem_wr_addr),
    .mem_wr_data_o(mem_wr_data), .mem_wr_done_i(mem_wr_done),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory responder with varying latency
  initial begin
    int rd_wait = 1, wr_wait = 0;
    for (int i = 0; i < 32; i++) mem_model[i] = 8'(i * 37 + 11);
    forever begin
      @(negedge clk);
      if (mem_rd_done) mem_rd_done = 1'b0;
      else if (mem_rd_req) begin
        if (rd_wait == 0) begin
          mem_rd_data = {mem_model[{mem_rd_line, 1'b1}], mem_model[{mem_rd_line, 1'b0}]};
          mem_rd_done = 1'b1;
          rd_cnt++;
          rd_wait = rd_cnt % 3;
        end else rd_wait--;
      end
      if (mem_wr_done) mem_wr_done = 1'b0;
      else if (mem_wr_req) begin
        if (wr_wait == 0) begin
          mem_model[mem_wr_addr] = mem_wr_data;
          last_wr_addr = mem_wr_addr;
          last_wr_data = mem_wr_data;
          mem_wr_done = 1'b1;
          wr_cnt++;
          wr_wait = (wr_cnt + 1) % 3;
        end else wr_wait--;
      end
    end
  end

  task automatic access(input bit st, input logic [4:0] a, input logic [7:0] d);
    bit hit = 1'b0, way = 1'b0;
    int rd0 = rd_cnt, wr0 = wr_cnt, cyc = 0;
    for (int w = 0; w < 2; w++)
      if (m_valid[w] && m_tag[w] == a[4:1]) begin hit = 1'b1; way = w[0]; end
    if (!hit) begin
      way = !m_valid[0] ? 1'b0 : (!m_valid[1] ? 1'b1 : m_lru);
      m_valid[way] = 1'b1;
      m_tag[way] = a[4:1];
      exp_misses++;
    end else exp_hits++;
    m_lru = ~way;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk);
      cyc++;
      if (req_ready && (mem_rd_req || mem_wr_req))
        chk(1'b0, "R8", "ready while memory busy", 1, 0);
      if (mem_rd_req && mem_wr_req)
        chk(1'b0, "R9", "read and write together", 1, 0);
    end while (!req_ready);
    req_valid = 1'b0;
    chk(hit_cnt == 16'(exp_hits), "R3/R7", "hit count", hit_cnt, exp_hits);
    chk(miss_cnt == 16'(exp_misses), "R2/R7", "miss count", miss_cnt, exp_misses);
    chk(rd_cnt - rd0 == (hit ? 0 : 1), "R2", "line reads", rd_cnt - rd0, hit ? 0 : 1);
    chk(wr_cnt - wr0 == (st ? 1 : 0), "R6", "byte writes", wr_cnt - wr0, st ? 1 : 0);
    if (st) begin
      chk(last_wr_addr == a, "R4", "write address", last_wr_addr, a);
      chk(last_wr_data == d, "R5", "write data", last_wr_data, d);
    end else begin
      chk(rsp_rdata == mem_model[a], "R10", "load data", rsp_rdata, mem_model[a]);
      if (hit) chk(cyc == 1, "R3", "hit latency", cyc, 1);
    end
    @(negedge clk);
    chk(!req_ready, "R8", "ready pulse width", req_ready, 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_ready && !mem_rd_req && !mem_wr_req, "R1", "outputs in reset", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit_cnt == 0 && miss_cnt == 0, "R1", "counters after reset", hit_cnt + miss_cnt, 0);
    chk(!req_ready, "R1", "ready after reset", req_ready, 0);

    // short mixed pattern
    access(1'b0, 5'd1, 8'h00);
    access(1'b0, 5'd7, 8'h00);
    access(1'b1, 5'd0, 8'h17);
    access(1'b1, 5'd5, 8'h42);
    access(1'b0, 5'd10, 8'h00);
    access(1'b1, 5'd5, 8'h99);
    access(1'b1, 5'd10, 8'h3C);
    access(1'b0, 5'd11, 8'h00);

    // R7: two valid lines, recency decides the victim
    access(1'b0, 5'd20, 8'h00);
    access(1'b0, 5'd22, 8'h00);
    access(1'b0, 5'd21, 8'h00);
    access(1'b0, 5'd24, 8'h00);
    access(1'b0, 5'd20, 8'h00);

    // R5: every address, store then both bytes of its line
    for (int i = 0; i < 32; i++) begin
      access(1'b1, 5'(i), 8'(i ^ 8'h5A));
      access(1'b0, 5'(i), 8'h00);
      access(1'b0, 5'(i ^ 1), 8'h00);
    end

    // R4/R10: pseudo-random sweep over a small working set and the whole space
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[5], (i < 200) ? {3'b000, lfsr[1:0]} : lfsr[4:0], lfsr[15:8]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule